// File: doc/BRIEF.md
# Flash Page Program Buffer Manager

This block stages data for a flash program operation and then applies it to an array model. During a setup phase, word writes from the bus fill a set of program buffers. Together these buffers hold one page. The first write of the phase also fixes which page inside each array block is the target. A separate mask register chooses the array blocks that receive the data. A start pulse then copies the whole staged page into every chosen block, one word per clock. While it does so, a busy output stays high.

The array follows flash program rules. A stored bit can only go from 1 to 0, so each stored word becomes the old word ANDed with the staged word. A page may be programmed only once between erases. The block keeps one flag per page of every block. If a start targets a page that is already flagged, the start is refused and an error is raised. A start with an empty block mask is also refused and raises its own error. Reset puts the array in the erased state: every bit is 1 and every flag is clear.

Top module: `fpb_prog_buf_mgr`

## Requirements
- R1: After reset, every array word reads all ones, no page is flagged, and busy, err_empty and err_reprog are low.
- R2: In a setup phase (prog_mode high), the first accepted write latches the target page from address bits [9+] (above the 512-byte page). Page bits of later writes in the same phase are ignored.
- R3: rd_data combinationally shows the stored word of block rd_blk at word address rd_addr. rd_addr is {page, word index}, with the page in the top bit.
- R4: A write selects the staging word by byte-address bits [8:2]: bits [8:6] pick one of eight 64-byte buffers and bits [5:2] pick the word in that buffer. Bits [1:0] are ignored, and a repeated write to a word replaces it. An accepted start sets each word i of the target page in each selected block to old AND staged word i. Staging words not written in the phase hold all ones.
- R5: A program operation leaves unselected blocks and other pages unchanged.
- R6: A start whose mask selects a block whose target page is already flagged is refused. err_reprog goes high, busy stays low and the array is unchanged. A completed operation flags the target page of every selected block, and a flag never clears before reset.
- R7: busy rises in the cycle after an accepted start and stays high for exactly 128 cycles per selected block. busy never rises without a start.
- R8: A start with an all-zero mask is refused and err_empty goes high. Both error outputs hold until the next start seen while idle, which rewrites both.
- R9: With prog_mode low and the block idle, the staging words return to all ones, the latched page is forgotten, and bus writes are ignored.
- R10: While busy, bus writes, mask loads and start pulses are ignored, and the latched page stays stable.
- R11: mask_we loads the block mask while idle. The mask persists across operations and setup phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | Setup phase enable |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 10 | Byte address of the write |
| wr_data | input | 32 | Write data |
| mask_we | input | 1 | Load strobe for the block mask |
| mask_in | input | 4 | New block mask, one bit per array block |
| start | input | 1 | Program start pulse |
| rd_blk | input | 2 | Read port block index |
| rd_addr | input | 8 | Read port word address within the block |
| rd_data | output | 32 | Read port data |
| busy | output | 1 | Apply phase in progress |
| err_empty | output | 1 | Last start had an empty mask |
| err_reprog | output | 1 | Last start hit an already programmed page |

## Verification
The bench builds the block with its default parameters: eight 64-byte buffers of 32-bit words, four blocks and two pages per block. This gives a 1024-word array. The read port can sweep the whole array in one pass while idle, so every word of every block and page is compared after each operation. The small page count lets the test reach the flagged-page refusal on both pages. Four blocks allow disjoint masks of two blocks each, and a single-block run, so the 256-cycle and 128-cycle busy lengths are both measured.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_APPLY = 1'b1
    } seq_state_e;
endpackage

// File: rtl/fpb_stage.sv
// Staging buffers and page offset capture. Sizes must be powers of two.
module fpb_stage #(
    parameter int NUM_BUF       = 8,
    parameter int BUF_BYTES     = 64,
    parameter int DATA_W        = 32,
    parameter int PAGES_PER_BLK = 2,
    localparam int WORD_BYTES   = DATA_W / 8,
    localparam int BUF_WORDS    = BUF_BYTES / WORD_BYTES,
    localparam int PAGE_WORDS   = NUM_BUF * BUF_WORDS,
    localparam int BOFF_W       = $clog2(WORD_BYTES),
    localparam int WSEL_W       = $clog2(BUF_WORDS),
    localparam int BSEL_W       = $clog2(NUM_BUF),
    localparam int IDX_W        = $clog2(PAGE_WORDS),
    localparam int PAGE_W       = $clog2(PAGES_PER_BLK),
    localparam int ADDR_W       = PAGE_W + IDX_W + BOFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word,
    output logic [PAGE_W-1:0] off_page,
    output logic              off_valid
);

    typedef struct packed {
        logic [PAGE_WORDS-1:0][DATA_W-1:0] words;
        logic [PAGE_W-1:0]                 page;
        logic                              valid;
    } stage_t;

    stage_t q, d;

    logic              accept;
    logic [NUM_BUF-1:0] buf_hit;
    logic [WSEL_W-1:0] wsel;
    logic [BSEL_W-1:0] bsel;
    logic              unused_byte_bits;

    assign accept = prog_mode && !busy && wr_en;
    assign wsel   = wr_addr[BOFF_W +: WSEL_W];
    assign bsel   = wr_addr[BOFF_W + WSEL_W +: BSEL_W];
    assign unused_byte_bits = ^wr_addr[BOFF_W-1:0];

    // one decoder per 64-byte buffer
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf_dec
        assign buf_hit[b] = accept && (bsel == BSEL_W'(b));
    end

    always_comb begin
        d = q;
        if (!prog_mode && !busy) begin
            d.words = '1;
            d.page  = '0;
            d.valid = 1'b0;
        end else if (accept) begin
            if (!q.valid) begin
                d.page  = wr_addr[ADDR_W-1 -: PAGE_W];
                d.valid = 1'b1;
            end
            for (int b = 0; b < NUM_BUF; b++) begin
                if (buf_hit[b]) begin
                    d.words[{BSEL_W'(b), wsel}] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.words <= '1;
            q.page  <= '0;
            q.valid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_word   = q.words[rd_idx];
    assign off_page  = q.page;
    assign off_valid = q.valid;

endmodule

// File: rtl/fpb_seq.sv
// Start decision and apply walk over selected blocks.
module fpb_seq
    import fpb_pkg::*;
#(
    parameter int NUM_BLK       = 4,
    parameter int PAGES_PER_BLK = 2,
    parameter int PAGE_WORDS    = 128,
    localparam int BLK_W        = $clog2(NUM_BLK),
    localparam int PAGE_W       = $clog2(PAGES_PER_BLK),
    localparam int IDX_W        = $clog2(PAGE_WORDS),
    localparam int NFLAG        = NUM_BLK * PAGES_PER_BLK
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mask_we,
    input  logic [NUM_BLK-1:0] mask_in,
    input  logic [PAGE_W-1:0]  page_in,
    input  logic [NFLAG-1:0]   flags,
    output logic               busy,
    output logic [NUM_BLK-1:0] sel_mask,
    output logic               arr_we,
    output logic [BLK_W-1:0]   arr_blk,
    output logic [PAGE_W-1:0]  arr_page,
    output logic [IDX_W-1:0]   arr_idx,
    output logic               flag_we,
    output logic [NUM_BLK-1:0] flag_mask,
    output logic [PAGE_W-1:0]  flag_page,
    output logic               err_empty,
    output logic               err_reprog
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_WORDS - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [NUM_BLK-1:0] mask;
        logic [NUM_BLK-1:0] remain;
        logic [IDX_W-1:0]   idx;
        logic [PAGE_W-1:0]  page;
        logic               err_e;
        logic               err_r;
    } seq_t;

    seq_t q, d;

    logic [BLK_W-1:0] cur_blk;
    logic             hit;
    logic             flag_we_d;

    // lowest remaining block is served first
    always_comb begin
        cur_blk = '0;
        for (int b = NUM_BLK - 1; b >= 0; b--) begin
            if (q.remain[b]) cur_blk = BLK_W'(b);
        end
    end

    always_comb begin
        hit = 1'b0;
        for (int b = 0; b < NUM_BLK; b++) begin
            if (q.mask[b] && flags[b * PAGES_PER_BLK + int'(page_in)]) hit = 1'b1;
        end
    end

    always_comb begin
        d         = q;
        flag_we_d = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (q.mask == '0) begin
                        d.err_e = 1'b1;
                        d.err_r = 1'b0;
                    end else if (hit) begin
                        d.err_e = 1'b0;
                        d.err_r = 1'b1;
                    end else begin
                        d.err_e  = 1'b0;
                        d.err_r  = 1'b0;
                        d.st     = ST_APPLY;
                        d.remain = q.mask;
                        d.idx    = '0;
                        d.page   = page_in;
                    end
                end
                if (mask_we) d.mask = mask_in;
            end
            ST_APPLY: begin
                if (q.idx == LAST_IDX) begin
                    d.idx             = '0;
                    d.remain[cur_blk] = 1'b0;
                    if (d.remain == '0) begin
                        d.st      = ST_IDLE;
                        flag_we_d = 1'b1;
                    end
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.mask   <= '0;
            q.remain <= '0;
            q.idx    <= '0;
            q.page   <= '0;
            q.err_e  <= 1'b0;
            q.err_r  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.st == ST_APPLY);
    assign sel_mask   = q.mask;
    assign arr_we     = busy;
    assign arr_blk    = cur_blk;
    assign arr_page   = q.page;
    assign arr_idx    = q.idx;
    assign flag_we    = flag_we_d;
    assign flag_mask  = q.mask;
    assign flag_page  = q.page;
    assign err_empty  = q.err_e;
    assign err_reprog = q.err_r;

endmodule

// File: rtl/fpb_array.sv
// Array model with program (AND) semantics and per-page programmed flags.
module fpb_array #(
    parameter int NUM_BLK       = 4,
    parameter int PAGES_PER_BLK = 2,
    parameter int PAGE_WORDS    = 128,
    parameter int DATA_W        = 32,
    localparam int BLK_W        = $clog2(NUM_BLK),
    localparam int PAGE_W       = $clog2(PAGES_PER_BLK),
    localparam int IDX_W        = $clog2(PAGE_WORDS),
    localparam int MEM_AW       = BLK_W + PAGE_W + IDX_W,
    localparam int MEM_WORDS    = 1 << MEM_AW,
    localparam int NFLAG        = NUM_BLK * PAGES_PER_BLK
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [BLK_W-1:0]          wblk,
    input  logic [PAGE_W-1:0]         wpage,
    input  logic [IDX_W-1:0]          widx,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      flag_we,
    input  logic [NUM_BLK-1:0]        flag_mask,
    input  logic [PAGE_W-1:0]         flag_page,
    output logic [NFLAG-1:0]          flags,
    input  logic [BLK_W-1:0]          rd_blk,
    input  logic [PAGE_W+IDX_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]         rd_data
);

    logic [DATA_W-1:0] mem_q [MEM_WORDS];
    logic [MEM_AW-1:0] waddr;
    logic [DATA_W-1:0] word_d;
    logic [NFLAG-1:0]  flags_q, flags_d;

    assign waddr  = {wblk, wpage, widx};
    assign word_d = mem_q[waddr] & wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_WORDS; i++) mem_q[i] <= '1;
        end else if (we) begin
            mem_q[waddr] <= word_d;
        end
    end

    always_comb begin
        flags_d = flags_q;
        if (flag_we) begin
            for (int b = 0; b < NUM_BLK; b++) begin
                if (flag_mask[b]) flags_d[b * PAGES_PER_BLK + int'(flag_page)] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags   = flags_q;
    assign rd_data = mem_q[{rd_blk, rd_addr}];

endmodule

// File: rtl/fpb_prog_buf_mgr.sv
module fpb_prog_buf_mgr #(
    parameter int NUM_BUF       = 8,
    parameter int BUF_BYTES     = 64,
    parameter int DATA_W        = 32,
    parameter int NUM_BLK       = 4,
    parameter int PAGES_PER_BLK = 2,
    localparam int WORD_BYTES   = DATA_W / 8,
    localparam int PAGE_WORDS   = NUM_BUF * BUF_BYTES / WORD_BYTES,
    localparam int IDX_W        = $clog2(PAGE_WORDS),
    localparam int PAGE_W       = $clog2(PAGES_PER_BLK),
    localparam int BLK_W        = $clog2(NUM_BLK),
    localparam int ADDR_W       = PAGE_W + IDX_W + $clog2(WORD_BYTES),
    localparam int NFLAG        = NUM_BLK * PAGES_PER_BLK
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    prog_mode,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    mask_we,
    input  logic [NUM_BLK-1:0]      mask_in,
    input  logic                    start,
    input  logic [BLK_W-1:0]        rd_blk,
    input  logic [PAGE_W+IDX_W-1:0] rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    busy,
    output logic                    err_empty,
    output logic                    err_reprog
);

    logic [DATA_W-1:0]  stage_word;
    logic [PAGE_W-1:0]  off_page;
    logic               off_valid;
    logic [NUM_BLK-1:0] sel_mask;
    logic               arr_we;
    logic [BLK_W-1:0]   arr_blk;
    logic [PAGE_W-1:0]  arr_page;
    logic [IDX_W-1:0]   arr_idx;
    logic               flag_we;
    logic [NUM_BLK-1:0] flag_mask;
    logic [PAGE_W-1:0]  flag_page;
    logic [NFLAG-1:0]   flags;

    fpb_stage #(
        .NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES),
        .DATA_W(DATA_W), .PAGES_PER_BLK(PAGES_PER_BLK)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .busy(busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_idx(arr_idx), .rd_word(stage_word),
        .off_page(off_page), .off_valid(off_valid)
    );

    fpb_seq #(
        .NUM_BLK(NUM_BLK), .PAGES_PER_BLK(PAGES_PER_BLK), .PAGE_WORDS(PAGE_WORDS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mask_we(mask_we),
        .mask_in(mask_in), .page_in(off_page), .flags(flags),
        .busy(busy), .sel_mask(sel_mask), .arr_we(arr_we), .arr_blk(arr_blk),
        .arr_page(arr_page), .arr_idx(arr_idx), .flag_we(flag_we),
        .flag_mask(flag_mask), .flag_page(flag_page),
        .err_empty(err_empty), .err_reprog(err_reprog)
    );

    fpb_array #(
        .NUM_BLK(NUM_BLK), .PAGES_PER_BLK(PAGES_PER_BLK),
        .PAGE_WORDS(PAGE_WORDS), .DATA_W(DATA_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .wblk(arr_blk),
        .wpage(arr_page), .widx(arr_idx), .wdata(stage_word),
        .flag_we(flag_we), .flag_mask(flag_mask), .flag_page(flag_page),
        .flags(flags), .rd_blk(rd_blk), .rd_addr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: rtl/fpb_prog_buf_chk.sv
module fpb_prog_buf_chk #(
    parameter int NUM_BLK = 4,
    parameter int PAGE_W  = 1,
    parameter int NFLAG   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               prog_mode,
    input logic               busy,
    input logic               err_empty,
    input logic               err_reprog,
    input logic [NUM_BLK-1:0] sel_mask,
    input logic [PAGE_W-1:0]  off_page,
    input logic               off_valid,
    input logic [NFLAG-1:0]   flags
);

    // R2: latched page holds for the rest of the setup phase
    a_r2_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (off_valid && prog_mode) |=> $stable(off_page));

    // R6: a refused start never leaves the block busy
    a_r6_reprog_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_reprog |-> !busy);

    // R6: page flags only accumulate
    a_r6_flags_keep: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((flags & $past(flags)) == $past(flags)));

    // R7: busy starts only from a start pulse
    a_r7_rise_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R8: empty mask refuses the start
    a_r8_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (sel_mask == '0)) |=> (err_empty && !busy));

    // R10: staging page cannot move while applying
    a_r10_page_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(off_page));

endmodule

bind fpb_prog_buf_mgr fpb_prog_buf_chk #(
    .NUM_BLK(NUM_BLK), .PAGE_W(PAGE_W), .NFLAG(NFLAG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .prog_mode(prog_mode),
    .busy(busy), .err_empty(err_empty), .err_reprog(err_reprog),
    .sel_mask(sel_mask), .off_page(off_page), .off_valid(off_valid),
    .flags(flags)
);

// File: tb/test_fpb_prog_buf_mgr.sv
module test_fpb_prog_buf_mgr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        mask_we = 1'b0;
    logic [3:0]  mask_in = '0;
    logic        start = 1'b0;
    logic [1:0]  rd_blk = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        busy, err_empty, err_reprog;

    always #2 clk = ~clk;

    fpb_prog_buf_mgr i_fpb_prog_buf_mgr (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .mask_we(mask_we),
        .mask_in(mask_in), .start(start), .rd_blk(rd_blk), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .err_empty(err_empty),
        .err_reprog(err_reprog)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 0;
    bit    started = 0;
    string phase = "R1";
    int    sweep = 0;
    int    run_len = 0;
    int    last_run = 0;

    // behavioural reference model
    int          m_cnt;
    logic [3:0]  m_mask, m_apply_mask;
    int          m_page, m_apply_page;
    bit          m_have, m_ee, m_er, m_hit;
    logic [31:0] m_buf [128];
    logic [31:0] m_mem [1024];
    bit          m_flag [8];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mask = '0; m_apply_mask = '0; m_page = 0; m_apply_page = 0;
            m_have = 0; m_ee = 0; m_er = 0;
            for (int i = 0; i < 128; i++) m_buf[i] = '1;
            for (int i = 0; i < 1024; i++) m_mem[i] = '1;
            for (int i = 0; i < 8; i++) m_flag[i] = 0;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                for (int b = 0; b < 4; b++) begin
                    if (m_apply_mask[b]) begin
                        for (int i = 0; i < 128; i++)
                            m_mem[b*256 + m_apply_page*128 + i] &= m_buf[i];
                        m_flag[b*2 + m_apply_page] = 1;
                    end
                end
            end
        end else begin
            if (start) begin
                if (m_mask == 0) begin
                    m_ee = 1; m_er = 0;
                end else begin
                    m_hit = 0;
                    for (int b = 0; b < 4; b++)
                        if (m_mask[b] && m_flag[b*2 + m_page]) m_hit = 1;
                    m_ee = 0;
                    m_er = m_hit;
                    if (!m_hit) begin
                        m_apply_mask = m_mask;
                        m_apply_page = m_page;
                        m_cnt = $countones(m_mask) * 128;
                    end
                end
            end
            if (mask_we) m_mask = mask_in;
            if (!prog_mode) begin
                for (int i = 0; i < 128; i++) m_buf[i] = '1;
                m_have = 0; m_page = 0;
            end else if (wr_en) begin
                if (!m_have) begin
                    m_page = int'(wr_addr[9]);
                    m_have = 1;
                end
                m_buf[wr_addr[8:2]] = wr_data;
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && started) begin
            rd_blk  = sweep[9:8];
            rd_addr = sweep[7:0];
            #1;
            check({"R7 busy [", phase, "]"}, {31'd0, busy}, {31'd0, m_cnt > 0});
            check({"R8 err_empty [", phase, "]"}, {31'd0, err_empty}, {31'd0, m_ee});
            check({"R6 err_reprog [", phase, "]"}, {31'd0, err_reprog}, {31'd0, m_er});
            if (m_cnt == 0)
                check({"R3 R4 R5 array word [", phase, "]"}, rd_data, m_mem[sweep]);
            if (busy) run_len++;
            else if (run_len > 0) begin
                last_run = run_len;
                run_len  = 0;
            end
            sweep = (sweep + 1) % 1024;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(logic [9:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_mask(logic [3:0] m);
        mask_we = 1'b1; mask_in = m;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic set_mode(logic v);
        prog_mode = v;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 err_empty after reset", {31'd0, err_empty}, 32'd0);
        check("R1 err_reprog after reset", {31'd0, err_reprog}, 32'd0);
        started = 1;
        @(negedge clk);
        idle(1100);

        // offset capture, replace-on-rewrite, AND into erased page 1
        phase = "R2 R4 R11";
        load_mask(4'b0101);
        set_mode(1'b1);
        write_word({1'b1, 7'd5, 2'b00}, 32'hA5A5_0F0F);
        write_word({1'b0, 7'd127, 2'b11}, 32'h1234_5678);
        write_word({1'b0, 7'd5, 2'b00}, 32'hFFFF_00FF);
        write_word({1'b0, 7'd40, 2'b00}, 32'h0000_0000);
        pulse_start();
        idle(20);
        // inputs during apply must be ignored
        phase = "R10";
        write_word({1'b1, 7'd127, 2'b00}, 32'h0000_0000);
        load_mask(4'b0000);
        pulse_start();
        idle(300);
        idle(1100);
        check("R7 busy length two blocks", last_run, 32'd256);

        // leaving setup clears buffers; writes while idle mode are dropped
        phase = "R9 R11";
        set_mode(1'b0);
        write_word({1'b0, 7'd3, 2'b00}, 32'h0000_0000);
        idle(2);
        set_mode(1'b1);
        pulse_start();
        idle(300);
        idle(1100);
        check("R11 mask kept, two-block length", last_run, 32'd256);

        // same page again, then page 1 again
        phase = "R6";
        pulse_start();
        idle(5);
        set_mode(1'b0);
        idle(2);
        set_mode(1'b1);
        write_word({1'b1, 7'd64, 2'b00}, 32'h0000_FFFF);
        pulse_start();
        idle(5);

        // empty mask, then other blocks on page 1
        phase = "R8 R5";
        load_mask(4'b0000);
        pulse_start();
        idle(5);
        load_mask(4'b1010);
        pulse_start();
        idle(300);
        idle(1100);

        // single-block apply
        phase = "R7";
        set_mode(1'b0);
        idle(2);
        set_mode(1'b1);
        write_word({1'b0, 7'd0, 2'b00}, 32'h0F0F_0F0F);
        load_mask(4'b1000);
        pulse_start();
        idle(200);
        idle(1100);
        check("R7 busy length one block", last_run, 32'd128);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule